// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block sequences a memory core into and out of a low-power sleep state. The sleep request arrives on a pin with no timing relation to the clock. The block first resynchronizes it, then counts a fixed number of clock cycles for entry and the same kind of count for exit. While the sequencer is anywhere other than fully awake, it withholds the ready indication. Host accesses are granted only when the core is ready. Stored contents are left untouched throughout, because the block never issues an access while asleep.

Accesses that are in flight when entry begins are dropped: no grant is given for them. The controller must be deselected before sleep starts and must stay deselected for the whole recovery window after the request is released. If a full chip selection shows up while the sequencer is entering or recovering, the block raises a sticky protocol-violation flag and ignores that access. The block carries no data stream. Every pin is a plain level-sensitive control or status signal, with no valid/ready handshake.

Top module: `doze_ctrl`

## Requirements
- R1: During reset and right after it, sleep_active and guard_viol are 0 and ready is 1. access_ok equals 1 exactly when every chip_en bit is 1.
- R2: The request passes through a two-flop synchronizer. Take edge 1 as the first rising edge that samples a new request level of 1 while awake. ready falls after edge 2.
- R3: With the request held high, sleep_active rises after edge 5. That is two synchronizer edges, the edge that starts entry, and ENTRY_CYC=2 entry cycles.
- R4: Take edge 1 as the first rising edge that samples the request low while asleep. sleep_active falls after edge 3, and ready rises after edge 5, after EXIT_CYC=2 recovery cycles.
- R5: If the synchronized request drops while entry is still counting, the sequencer goes straight into recovery. sleep_active never rises, and ready returns only after the full exit count.
- R6: If the synchronized request returns during recovery, entry restarts at once and ready stays low.
- R7: access_ok is 1 only when ready is 1 and all chip_en bits are 1. A selection made while not ready produces no grant.
- R8: A full selection (all chip_en bits 1) in any cycle spent entering or recovering sets guard_viol. guard_viol then stays 1 until reset.
- R9: A full selection while asleep grants nothing and does not set guard_viol.
- R10: sleep_active and ready are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_async | input | 1 | Sleep request, asynchronous to clk, active high |
| chip_en | input | NUM_SEL | Chip-enable qualifiers, active high; the core is selected when all bits are 1 |
| sleep_active | output | 1 | Core is fully asleep |
| ready | output | 1 | Core is awake with no request pending |
| access_ok | output | 1 | Selection accepted this cycle |
| guard_viol | output | 1 | Sticky flag: selection during entry or recovery |

## Verification
The delicate coincidence is the synchronized request coming back in the same cycle that the recovery count reaches its last step. Finishing recovery and restarting entry then compete for the next state. The bench provokes this by dropping the request after sleep and raising it again a chosen number of cycles later, so that its synchronized copy lands on the final recovery cycle. A behavioural reference model compared on every clock requires entry to win: ready must stay low. A second coincidence, a full selection on that same cycle, must also set the violation flag, and the model checks that too.

// File: rtl/doze_pkg.sv
package doze_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_RECOVER = 2'd3
  } doze_state_t;
endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/doze_fsm.sv
module doze_fsm
  import doze_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_s,
  output doze_state_t state,
  output logic        in_guard,
  output logic        sleep_active,
  output logic        ready
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC);
  localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC);
  localparam logic [CW-1:0] ONE      = CW'(1);

  doze_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic last_step;

  assign last_step = (cnt_q == ONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        if (req_s) begin
          state_d = ST_ENTER;
          cnt_d   = ENTRY_LD;
        end
      end
      ST_ENTER: begin
        if (!req_s) begin
          state_d = ST_RECOVER;
          cnt_d   = EXIT_LD;
        end else if (last_step) begin
          state_d = ST_SLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_SLEEP: begin
        if (!req_s) begin
          state_d = ST_RECOVER;
          cnt_d   = EXIT_LD;
        end
      end
      ST_RECOVER: begin
        if (req_s) begin
          state_d = ST_ENTER;
          cnt_d   = ENTRY_LD;
        end else if (last_step) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state        = state_q;
  assign in_guard     = (state_q == ST_ENTER) || (state_q == ST_RECOVER);
  assign sleep_active = (state_q == ST_SLEEP);
  assign ready        = (state_q == ST_AWAKE) && !req_s;

  // R3: sleep is only reached through the entry sequence
  a_r3_sleep_via_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(state_q) == ST_ENTER);

  // R4: a released request while asleep moves into recovery next cycle
  a_r4_sleep_to_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_active && !req_s) |=> state_q == ST_RECOVER);

  // R5: a dropped request during entry never reaches sleep
  a_r5_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENTER && !req_s) |=> !sleep_active);

  // R10: sleep and ready are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_active && ready));
endmodule

// File: rtl/doze_guard.sv
module doze_guard #(
  parameter int NUM_SEL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEL-1:0] chip_en,
  input  logic               in_guard,
  input  logic               ready,
  output logic               access_ok,
  output logic               viol
);
  logic selected;
  logic viol_q;

  assign selected = &chip_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    viol_q <= 1'b0;
    else if (in_guard && selected) viol_q <= 1'b1;
  end

  assign viol      = viol_q;
  assign access_ok = selected && ready;

  // R8: violation flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q);

  // R8: flag is raised by a guarded-window selection
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_guard && selected) |=> viol_q);

  // R7: no grant without ready
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> ready);
endmodule

// File: rtl/doze_ctrl.sv
module doze_ctrl
  import doze_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int NUM_SEL     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req_async,
  input  logic [NUM_SEL-1:0] chip_en,
  output logic               sleep_active,
  output logic               ready,
  output logic               access_ok,
  output logic               guard_viol
);
  logic        req_s;
  logic        in_guard;
  doze_state_t state;

  doze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sleep_req_async),
    .sync_out (req_s)
  );

  doze_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_s        (req_s),
    .state        (state),
    .in_guard     (in_guard),
    .sleep_active (sleep_active),
    .ready        (ready)
  );

  doze_guard #(.NUM_SEL(NUM_SEL)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .in_guard  (in_guard),
    .ready     (ready),
    .access_ok (access_ok),
    .viol      (guard_viol)
  );

  // R9: selection while asleep grants nothing and leaves the flag alone
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !guard_viol) |=> !(guard_viol && $past(state) == ST_SLEEP && $past(state) == state));

  // R7: a grant is only ever given with a full selection
  a_r7_full_sel: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> (&chip_en));
endmodule

// File: tb/doze_ctrl_bench.sv
module doze_ctrl_bench;
  localparam int NS = 3;
  localparam int ENTRY_CYC = 2;
  localparam int EXIT_CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [NS-1:0] chip_en = '0;
  logic sleep_active, ready, access_ok, guard_viol;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  doze_ctrl #(.SYNC_STAGES(2), .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .NUM_SEL(NS)) u_doze_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req_async(req), .chip_en(chip_en),
    .sleep_active(sleep_active), .ready(ready), .access_ok(access_ok), .guard_viol(guard_viol)
  );

  // reference model: 0 awake, 1 entering, 2 asleep, 3 recovering
  int m_st, m_cnt;
  bit m_p1, m_p2, m_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_p1 = 0; m_p2 = 0; m_v = 0;
    end else begin
      bit s;
      s = m_p2;
      if ((m_st == 1 || m_st == 3) && (&chip_en)) m_v = 1;
      case (m_st)
        0: if (s) begin m_st = 1; m_cnt = ENTRY_CYC; end
        1: if (!s) begin m_st = 3; m_cnt = EXIT_CYC; end
           else if (m_cnt == 1) m_st = 2;
           else m_cnt--;
        2: if (!s) begin m_st = 3; m_cnt = EXIT_CYC; end
        default: if (s) begin m_st = 1; m_cnt = ENTRY_CYC; end
           else if (m_cnt == 1) m_st = 0;
           else m_cnt--;
      endcase
      m_p2 = m_p1;
      m_p1 = req;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit e_rdy;
      e_rdy = (m_st == 0) && !m_p2;
      chk(sleep_active == (m_st == 2), "R3/R4 sleep_active", sleep_active, m_st == 2);
      chk(ready == e_rdy, "R2/R6 ready", ready, e_rdy);
      chk(access_ok == (e_rdy && (&chip_en)), "R7 access_ok", access_ok, e_rdy && (&chip_en));
      chk(guard_viol == m_v, "R8/R9 guard_viol", guard_viol, m_v);
      chk(!(sleep_active && ready), "R10 exclusive", sleep_active && ready, 0);
    end
  end

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive request at a negedge, count edges until cond reached
  task automatic measure_sleep_rise(output int n);
    n = 0;
    do begin @(negedge clk); #2; n++; end while (!sleep_active && n < 20);
  endtask

  initial begin
    int n;
    bit saw_sleep;
    // R1: reset state
    rst_n = 1'b0;
    chip_en = '1;
    #2;
    chk(sleep_active == 0, "R1 sleep during reset", sleep_active, 0);
    chk(ready == 1, "R1 ready during reset", ready, 1);
    chk(access_ok == 1, "R1 access_ok follows selection", access_ok, 1);
    chk(guard_viol == 0, "R1 viol during reset", guard_viol, 0);
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(2);
    chip_en = '0;

    // R2/R3: entry latency
    @(negedge clk); req = 1'b1;
    @(negedge clk); #2; chk(ready == 1, "R2 ready after edge 1", ready, 1);
    @(negedge clk); #2; chk(ready == 0, "R2 ready after edge 2", ready, 0);
    n = 2;
    do begin @(negedge clk); #2; n++; end while (!sleep_active && n < 20);
    chk(n == 5, "R3 sleep rises after edge 5", n, 5);

    // R9: select while asleep
    @(negedge clk); chip_en = '1;
    wait_edges(3); #2;
    chk(access_ok == 0, "R9 no grant asleep", access_ok, 0);
    chk(guard_viol == 0, "R9 no violation asleep", guard_viol, 0);
    @(negedge clk); chip_en = '0;

    // R4: exit latency
    @(negedge clk); req = 1'b0;
    wait_edges(2); #2; chk(sleep_active == 1, "R4 still asleep after edge 2", sleep_active, 1);
    @(negedge clk); #2; chk(sleep_active == 0, "R4 sleep falls after edge 3", sleep_active, 0);
    @(negedge clk); #2; chk(ready == 0, "R4 not ready after edge 4", ready, 0);
    @(negedge clk); #2; chk(ready == 1, "R4 ready after edge 5", ready, 1);

    // R5: request held for two edges aborts entry
    wait_edges(2);
    @(negedge clk); req = 1'b1;
    wait_edges(2); req = 1'b0;
    saw_sleep = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #2; if (sleep_active) saw_sleep = 1; end
    chk(saw_sleep == 0, "R5 aborted entry never sleeps", saw_sleep, 0);
    chk(ready == 1, "R5 ready after recovery", ready, 1);

    // R6: request returns on the last recovery cycle
    @(negedge clk); req = 1'b1;
    wait_edges(8);
    @(negedge clk); req = 1'b0;
    wait_edges(2); req = 1'b1;
    wait_edges(10); #2;
    chk(sleep_active == 1, "R6 re-entered sleep", sleep_active, 1);
    @(negedge clk); req = 1'b0;
    wait_edges(3); chip_en = '1;       // select during recovery
    @(negedge clk); chip_en = '0;
    wait_edges(4); #2;
    chk(guard_viol == 1, "R8 violation in recovery", guard_viol, 1);
    wait_edges(5); #2;
    chk(guard_viol == 1, "R8 violation sticky", guard_viol, 1);

    // R8: reset clears, then randomized traffic against the model
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #2;
    chk(guard_viol == 0, "R8 reset clears flag", guard_viol, 0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) req = ~req;
      chip_en = ($urandom_range(0, 9) == 0) ? '1 : NS'($urandom);
      if ($urandom_range(0, 400) == 0) rst_n = 1'b0; else rst_n = 1'b1;
    end
    rst_n = 1'b1;
    wait_edges(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule